// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This peripheral keeps wall-clock time as an unsigned 32-bit count of seconds. A programmable prescaler divides the reference clock by a frequency word holding the reference rate in Hz, producing one tick per second. Each tick advances the seconds counter while counting is enabled. At the end of the range the counter either rolls over to zero or holds at all ones, depending on a control bit.

Software reaches the block over a simple 16-bit register bus. Each 32-bit quantity occupies a low half and a high half. To set the time, software stages a load value and sets a load request bit. To read the time, software sets a snapshot request bit. Both request bits read back as 1 while the operation is pending and clear themselves when it is done, so software can poll them. A 32-bit match register drives an alarm interrupt. The interrupt can be masked, forced and acknowledged.

Registers sit at 4-byte spacing, with the index taken from address bits [5:2]:

| Byte offset | Register |
|---|---|
| 0x00 | control |
| 0x04 / 0x08 | frequency word, low / high half |
| 0x0C / 0x10 | load value, low / high half |
| 0x14 / 0x18 | match value, low / high half |
| 0x1C | status |
| 0x20 / 0x24 | snapshot, low / high half |

Top module: `sec_rtc`

## Requirements
- R1: After reset the control word reads 0x0001. The frequency, load, count and snapshot registers read 0, and the match halves read 0xFFFF. Status reads 0 and irq is low.
- R2: Control bits are: 0 = run (active-low soft reset), 1 = count enable, 2 = wrap enable, 3 = load request, 4 = snapshot request, 5 = interrupt mask, 6 = interrupt force, 7 = interrupt clear. Bits 0, 1, 2, 5 and 6 read back as written. Bit 7 always reads 0. Bits 8 to 15 read 0.
- R3: While counting is enabled with frequency word F, the counter advances exactly once every max(F,1) clock cycles. The prescaler phase restarts each time counting is enabled.
- R4: With count enable at 0 the counter holds its value.
- R5: Writing 1 to control bit 3 makes bit 3 read 1 for exactly REQ_LAT cycles. After that the bit reads 0 and the counter holds the 32-bit load value.
- R6: Writing 1 to control bit 4 makes bit 4 read 1 for exactly REQ_LAT cycles. After that the bit reads 0 and the snapshot registers hold the counter value.
- R7: When a tick arrives with the counter at 0xFFFFFFFF, the counter becomes 0 if wrap enable is 1 and stays at 0xFFFFFFFF otherwise.
- R8: Status bit 0 reads 1 exactly while the counter equals the match value.
- R9: Status bit 1 becomes 1 on the first cycle of counter/match equality, but only if the mask is 0 at that cycle. It stays 1 until a 1 is written to control bit 7.
- R10: irq equals (status bit 1 OR control bit 6) AND NOT control bit 5.
- R11: While control bit 0 is 0, the counter and status bit 1 are held at 0 and load requests leave the counter at 0.
- R12: Writes to the status and snapshot offsets have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The bench builds the block with REQ_LAT = 3. This makes the busy window of each request long enough to count, so every load and snapshot checks that the request bit reads 1 for exactly three cycles. The bench programs frequency words from 0 to 4. With these small words, every combination of prescaler phase and enable window, up to several ticks, runs in a few hundred cycles. It compares each result with floor(window / max(F,1)). Loading values near 0xFFFFFFFF brings the wrap and saturation edge within one to four ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // register indices (byte offset / 4); software decodes these
    localparam int RX_CTRL   = 0;
    localparam int RX_FREQ_L = 1;
    localparam int RX_FREQ_H = 2;
    localparam int RX_LOAD_L = 3;
    localparam int RX_LOAD_H = 4;
    localparam int RX_MTCH_L = 5;
    localparam int RX_MTCH_H = 6;
    localparam int RX_STAT   = 7;
    localparam int RX_SNAP_L = 8;
    localparam int RX_SNAP_H = 9;

    // control bit positions
    localparam int B_RUN   = 0;
    localparam int B_EN    = 1;
    localparam int B_WRAP  = 2;
    localparam int B_LOAD  = 3;
    localparam int B_SNAP  = 4;
    localparam int B_MASK  = 5;
    localparam int B_FORCE = 6;
    localparam int B_CLR   = 7;

    // request slots in the sequencer array
    localparam int RQ_LOAD = 0;
    localparam int RQ_SNAP = 1;
    localparam int RQ_NUM  = 2;

    typedef struct packed {
        logic run;
        logic cnt_en;
        logic wrap_en;
        logic mask;
        logic force_irq;
    } ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && ((limit <= W'(1)) || (pre_q >= limit - W'(1)));
        pre_d = pre_q + W'(1);
        if (!run || tick) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/rtc_req_seq.sv
module rtc_req_seq #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int LW = $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.left == LW'(1));
        if (s_q.busy) begin
            s_d.left = s_q.left - LW'(1);
            if (done) begin
                s_d.busy = 1'b0;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.left = LW'(LAT);
        end
        busy = s_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic hit,
    input  logic mask,
    input  logic force_irq,
    input  logic clear,
    output logic sticky,
    output logic irq
);
    typedef struct packed {
        logic prev;
        logic stk;
    } alm_t;

    alm_t a_d, a_q;
    logic hit_rise;

    always_comb begin
        a_d      = a_q;
        hit_rise = hit && !a_q.prev;
        a_d.prev = hit && !hold;
        if (hold) begin
            a_d.stk = 1'b0;
        end else if (hit_rise && !mask) begin
            a_d.stk = 1'b1;
        end else if (clear) begin
            a_d.stk = 1'b0;
        end
        sticky = a_q.stk;
        irq    = !mask && (a_q.stk || force_irq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int REQ_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] freq;
        logic [CNT_W-1:0] ldv;
        logic [CNT_W-1:0] mtch;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } rtc_st_t;

    rtc_st_t r_d, r_q;

    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic              ctrl_wr;
    logic              tick;
    logic              hit;
    logic              alm_sticky;
    logic [RQ_NUM-1:0] req_start;
    logic [RQ_NUM-1:0] req_busy;
    logic [RQ_NUM-1:0] req_done;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr_en   = bus_sel && bus_wr;
    assign ctrl_wr = wr_en && (idx == IDX_W'(RX_CTRL));
    assign hit     = (r_q.cnt == r_q.mtch);

    assign req_start[RQ_LOAD] = ctrl_wr && bus_wdata[B_LOAD];
    assign req_start[RQ_SNAP] = ctrl_wr && bus_wdata[B_SNAP];

    rtc_prescaler #(.W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.ctrl.cnt_en && r_q.ctrl.run),
        .limit (r_q.freq),
        .tick  (tick)
    );

    for (genvar g = 0; g < RQ_NUM; g++) begin : g_req
        rtc_req_seq #(.LAT(REQ_LAT)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .start (req_start[g]),
            .busy  (req_busy[g]),
            .done  (req_done[g])
        );
    end

    rtc_alarm u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!r_q.ctrl.run),
        .hit       (hit),
        .mask      (r_q.ctrl.mask),
        .force_irq (r_q.ctrl.force_irq),
        .clear     (ctrl_wr && bus_wdata[B_CLR]),
        .sticky    (alm_sticky),
        .irq       (irq)
    );

    // next-state
    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.ctrl.run       = bus_wdata[B_RUN];
            r_d.ctrl.cnt_en    = bus_wdata[B_EN];
            r_d.ctrl.wrap_en   = bus_wdata[B_WRAP];
            r_d.ctrl.mask      = bus_wdata[B_MASK];
            r_d.ctrl.force_irq = bus_wdata[B_FORCE];
        end
        if (wr_en) begin
            case (idx)
                IDX_W'(RX_FREQ_L): r_d.freq[DATA_W-1:0]     = bus_wdata;
                IDX_W'(RX_FREQ_H): r_d.freq[CNT_W-1:DATA_W] = bus_wdata;
                IDX_W'(RX_LOAD_L): r_d.ldv[DATA_W-1:0]      = bus_wdata;
                IDX_W'(RX_LOAD_H): r_d.ldv[CNT_W-1:DATA_W]  = bus_wdata;
                IDX_W'(RX_MTCH_L): r_d.mtch[DATA_W-1:0]     = bus_wdata;
                IDX_W'(RX_MTCH_H): r_d.mtch[CNT_W-1:DATA_W] = bus_wdata;
                default: ;
            endcase
        end
        if (!r_q.ctrl.run) begin
            r_d.cnt = '0;
        end else if (req_done[RQ_LOAD]) begin
            r_d.cnt = r_q.ldv;
        end else if (tick) begin
            if (r_q.cnt != '1) begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
            end else if (r_q.ctrl.wrap_en) begin
                r_d.cnt = '0;
            end
        end
        if (req_done[RQ_SNAP]) begin
            r_d.snap = r_q.cnt;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (idx)
                IDX_W'(RX_CTRL): begin
                    bus_rdata[B_RUN]   = r_q.ctrl.run;
                    bus_rdata[B_EN]    = r_q.ctrl.cnt_en;
                    bus_rdata[B_WRAP]  = r_q.ctrl.wrap_en;
                    bus_rdata[B_LOAD]  = req_busy[RQ_LOAD];
                    bus_rdata[B_SNAP]  = req_busy[RQ_SNAP];
                    bus_rdata[B_MASK]  = r_q.ctrl.mask;
                    bus_rdata[B_FORCE] = r_q.ctrl.force_irq;
                end
                IDX_W'(RX_FREQ_L): bus_rdata = r_q.freq[DATA_W-1:0];
                IDX_W'(RX_FREQ_H): bus_rdata = r_q.freq[CNT_W-1:DATA_W];
                IDX_W'(RX_LOAD_L): bus_rdata = r_q.ldv[DATA_W-1:0];
                IDX_W'(RX_LOAD_H): bus_rdata = r_q.ldv[CNT_W-1:DATA_W];
                IDX_W'(RX_MTCH_L): bus_rdata = r_q.mtch[DATA_W-1:0];
                IDX_W'(RX_MTCH_H): bus_rdata = r_q.mtch[CNT_W-1:DATA_W];
                IDX_W'(RX_STAT): begin
                    bus_rdata[0] = hit;
                    bus_rdata[1] = alm_sticky;
                end
                IDX_W'(RX_SNAP_L): bus_rdata = r_q.snap[DATA_W-1:0];
                IDX_W'(RX_SNAP_H): bus_rdata = r_q.snap[CNT_W-1:DATA_W];
                default: bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.ctrl.run <= 1'b1;
            r_q.mtch     <= '1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cnt_en,
    input logic             wrap_en,
    input logic             mask,
    input logic             force_irq,
    input logic             ld_done,
    input logic [CNT_W-1:0] cnt,
    input logic             sticky,
    input logic             irq
);
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mask);

    a_r10_force_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (force_irq && !mask) |-> irq);

    a_r11_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !sticky));

    a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_en && !ld_done) |=> $stable(cnt));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_en && !ld_done && cnt == '1) |=> (cnt == '1));

    a_r9_set_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky) |-> $past(!mask));
endmodule

bind sec_rtc rtc_checker #(.CNT_W(2 * DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (r_q.ctrl.run),
    .cnt_en    (r_q.ctrl.cnt_en),
    .wrap_en   (r_q.ctrl.wrap_en),
    .mask      (r_q.ctrl.mask),
    .force_irq (r_q.ctrl.force_irq),
    .ld_done   (req_done[0]),
    .cnt       (r_q.cnt),
    .sticky    (alm_sticky),
    .irq       (irq)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
    localparam int LAT = 3;

    localparam logic [5:0] A_CTRL = 6'h00, A_FRQL = 6'h04, A_FRQH = 6'h08,
                           A_LDL  = 6'h0C, A_LDH  = 6'h10, A_MTL  = 6'h14,
                           A_MTH  = 6'h18, A_STAT = 6'h1C, A_SNL  = 6'h20,
                           A_SNH  = 6'h24;
    localparam logic [15:0] C_RUN = 16'h0001, C_EN = 16'h0002, C_WRAP = 16'h0004,
                            C_LOAD = 16'h0008, C_SNAP = 16'h0010, C_MASK = 16'h0020,
                            C_FRC = 16'h0040, C_CLR = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] cv = C_RUN;

    always #4 clk = ~clk;

    sec_rtc #(.DATA_W(16), .ADDR_W(6), .REQ_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr32(input logic [5:0] a, input logic [31:0] v);
        wr(a, v[15:0]);
        wr(a + 6'd4, v[31:16]);
    endtask

    // issue a request bit and count the cycles it reads 1
    task automatic request(input string tag, input logic [15:0] bitv);
        logic [15:0] d;
        int seen;
        seen = 0;
        wr(A_CTRL, cv | bitv);
        for (int k = 0; k < 50; k++) begin
            rd(A_CTRL, d);
            if ((d & bitv) == 16'h0) break;
            seen++;
        end
        check(tag, seen, LAT);
    endtask

    task automatic snap(output logic [31:0] v);
        logic [15:0] lo, hi;
        request("R6 snapshot busy cycles", C_SNAP);
        rd(A_SNL, lo);
        rd(A_SNH, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [31:0] v);
        wr32(A_LDL, v);
        request("R5 load busy cycles", C_LOAD);
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got running expected done");
        finish_up();
    end

    initial begin
        logic [15:0] d;
        logic [31:0] v;
        int f, got_irq;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl reset", d, 16'h0001);
        rd(A_FRQL, d); check("R1 freq reset", d, 16'h0000);
        rd(A_MTH, d);  check("R1 match reset", d, 16'hFFFF);
        rd(A_STAT, d); check("R1 status reset", d, 16'h0000);
        rd(A_SNL, d);  check("R1 snap reset", d, 16'h0000);
        check("R1 irq reset", irq, 1'b0);

        // R2 control readback
        wr(A_CTRL, C_RUN | C_WRAP | C_MASK | C_FRC | C_CLR | 16'hFF00);
        rd(A_CTRL, d); check("R2 ctrl readback", d, C_RUN | C_WRAP | C_MASK | C_FRC);
        wr(A_CTRL, cv);

        // R3 prescaler sweep
        for (int fw = 0; fw <= 4; fw++) begin
            for (int w = 0; w <= 7; w++) begin
                wr(A_CTRL, cv);
                load(32'd100);
                wr32(A_FRQL, fw);
                wr(A_CTRL, cv | C_EN);
                repeat (w) @(posedge clk);
                wr(A_CTRL, cv);
                snap(v);
                f = (fw < 1) ? 1 : fw;
                check("R3 ticks per window", v, 32'd100 + 32'((w + 1) / f));
            end
        end

        // R4 hold while disabled
        load(32'h1234_5678);
        repeat (20) @(posedge clk);
        snap(v); check("R4 hold disabled", v, 32'h1234_5678);
        check("R5 load value", v, 32'h1234_5678);

        // R7 wrap / saturate at F=1
        wr32(A_FRQL, 32'd1);
        cv = C_RUN | C_WRAP;
        wr(A_CTRL, cv); load(32'hFFFF_FFFE);
        wr(A_CTRL, cv | C_EN); repeat (2) @(posedge clk); wr(A_CTRL, cv);
        snap(v); check("R7 wrap", v, 32'h0000_0001);
        cv = C_RUN;
        wr(A_CTRL, cv); load(32'hFFFF_FFFE);
        wr(A_CTRL, cv | C_EN); repeat (4) @(posedge clk); wr(A_CTRL, cv);
        snap(v); check("R7 saturate", v, 32'hFFFF_FFFF);

        // R8 / R9 alarm by counting
        wr32(A_MTL, 32'd13);
        load(32'd10);
        wr(A_CTRL, cv | C_CLR);
        check("R10 irq idle", irq, 1'b0);
        rd(A_STAT, d); check("R8 status no match", d, 16'h0000);
        wr(A_CTRL, cv | C_EN);
        got_irq = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (irq) begin got_irq = 1; break; end
        end
        check("R9 alarm fires", got_irq, 1);
        wr(A_CTRL, cv);
        rd(A_STAT, d); check("R9 sticky after pass", d[1], 1'b1);
        wr(A_CTRL, cv | C_CLR);
        rd(A_STAT, d); check("R9 cleared", d[1], 1'b0);
        check("R10 irq after clear", irq, 1'b0);
        rd(A_CTRL, d); check("R2 clear reads 0", d[7], 1'b0);

        // R8 raw equality
        load(32'd13);
        rd(A_STAT, d); check("R8 raw match", d, 16'h0003);
        load(32'd14);
        rd(A_STAT, d); check("R9 sticky keeps", d, 16'h0002);
        wr(A_CTRL, cv | C_CLR);

        // masked match: no sticky, no irq
        cv = C_RUN | C_MASK;
        wr(A_CTRL, cv);
        load(32'd13);
        rd(A_STAT, d); check("R9 masked no set", d, 16'h0001);
        check("R10 masked irq", irq, 1'b0);

        // force
        wr(A_CTRL, cv | C_FRC);
        @(negedge clk); check("R10 force masked", irq, 1'b0);
        cv = C_RUN;
        wr(A_CTRL, cv | C_FRC);
        @(negedge clk); check("R10 force", irq, 1'b1);
        wr(A_CTRL, cv);
        @(negedge clk); check("R10 force off", irq, 1'b0);

        // R11 soft reset
        load(32'd500);
        cv = 16'h0000;
        wr(A_CTRL, cv);
        snap(v); check("R11 held zero", v, 32'd0);
        load(32'd77);
        snap(v); check("R11 load ignored", v, 32'd0);
        cv = C_RUN;
        wr(A_CTRL, cv);
        snap(v); check("R11 released", v, 32'd0);

        // R12 read-only and unmapped
        wr(A_STAT, 16'hFFFF);
        wr(A_SNL, 16'hABCD);
        wr(A_SNH, 16'hABCD);
        rd(A_SNL, d); check("R12 snap write ignored", d, 16'h0000);
        rd(A_STAT, d); check("R12 status write ignored", d, 16'h0000);
        rd(6'h28, d); check("R12 unmapped 0x28", d, 16'h0000);
        rd(6'h3C, d); check("R12 unmapped 0x3C", d, 16'h0000);

        finish_up();
    end
endmodule